// File: doc/BRIEF.md
# Level-Sensitive Interrupt Aggregator

This block gathers a set of level-sensitive interrupt request lines into one interrupt output for a processor. Each clock it takes a copy of the input levels into a status word. A registered output goes high whenever any captured line is also enabled. Software reads the status word over a simple single-cycle register bus.

Software changes the enables one line at a time. It writes a line index to a mask offset to disable that line, or to an unmask offset to enable it. After reset every line is enabled. The block flags every access that goes the wrong way on an offset, and every access to an offset it does not implement, with a one-cycle error pulse on one of two outputs.

The bus uses byte offsets inside a 16-byte window:
- 0x0 is the status word, read only.
- 0x4 is the mask port, write only.
- 0x8 is the unmask port, write only.
- 0xC is unimplemented.

Top module: `irq_aggr`

## Requirements
- R1: On each clock edge the status word takes the current level of every input line: bit i is 1 while line i is high and 0 while it is low.
- R2: `irq_o` is 1 exactly when the status word ANDed with the enable word is nonzero. It reflects the values held before the clock edge, so it changes one edge after the status or enable change that causes it.
- R3: A write to offset 0x4 clears the enable bit whose index is in write data bits [4:0]. The change takes effect at that edge.
- R4: A write to offset 0x8 sets the enable bit whose index is in write data bits [4:0]. The change takes effect at that edge.
- R5: While reset is high and after reset: the enable word is all ones, the status word and `bus_rdata_o` are 0, and `irq_o`, `err_illegal_o` and `err_unimpl_o` are 0.
- R6: Write data bits above bit 4 have no effect on which enable bit a mask or unmask write selects.
- R7: A write to offset 0x0 changes no state and raises `err_illegal_o` for the single cycle after the access.
- R8: A read from offset 0x4 or 0x8 returns 0 on `bus_rdata_o` and raises `err_illegal_o` for the single cycle after the access.
- R9: An access to any other offset returns 0 on a read and changes no state on a write. It raises `err_unimpl_o` for the single cycle after the access. At most one error output is high in any cycle.
- R10: A read from offset 0x0 puts the status word held before the access edge on `bus_rdata_o`, where it is valid from that edge until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines_i | input | 32 | Level-sensitive interrupt request lines |
| bus_valid_i | input | 1 | Access strobe, one access per cycle |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 4 | Byte offset inside the window |
| bus_wdata_i | input | 32 | Write data (line index in bits [4:0]) |
| bus_rdata_o | output | 32 | Registered read data |
| err_illegal_o | output | 1 | One-cycle pulse after a wrong-direction access |
| err_unimpl_o | output | 1 | One-cycle pulse after an access to an unused offset |
| irq_o | output | 1 | Registered interrupt request to the processor |

## Verification
A change on the input lines reaches the status word at the first edge. It reaches `irq_o` at the second edge. For this reason the bench waits two rising edges after driving lines before it compares `irq_o` with its model. An enable write takes effect at its access edge, and `irq_o` follows one edge later. Read data and both error pulses are registered at the access edge. The bench samples them 1 ns after that edge, and samples again one edge later to confirm that each error pulse has dropped.

// File: rtl/irq_aggr_pkg.sv
package irq_aggr_pkg;

  // Kind of bus access, decided from offset and direction
  typedef enum logic [2:0] {
    ACC_IDLE      = 3'd0,
    ACC_STATUS_RD = 3'd1,
    ACC_MASK_WR   = 3'd2,
    ACC_UNMASK_WR = 3'd3,
    ACC_WRONG_DIR = 3'd4,
    ACC_UNUSED    = 3'd5
  } acc_kind_e;

  // Byte offsets of the register window
  localparam int unsigned OFF_STATUS = 0;
  localparam int unsigned OFF_MASK   = 4;
  localparam int unsigned OFF_UNMASK = 8;

endpackage

// File: rtl/irq_aggr_decode.sv
module irq_aggr_decode
  import irq_aggr_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              valid_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  output acc_kind_e         kind_o
);

  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFF_STATUS);
  localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(OFF_MASK);
  localparam logic [ADDR_W-1:0] A_UNMASK = ADDR_W'(OFF_UNMASK);

  logic hit_status;
  logic hit_mask;
  logic hit_unmask;

  assign hit_status = (addr_i == A_STATUS);
  assign hit_mask   = (addr_i == A_MASK);
  assign hit_unmask = (addr_i == A_UNMASK);

  always_comb begin
    kind_o = ACC_IDLE;
    if (valid_i) begin
      if (hit_status) begin
        kind_o = write_i ? ACC_WRONG_DIR : ACC_STATUS_RD;
      end else if (hit_mask) begin
        kind_o = write_i ? ACC_MASK_WR : ACC_WRONG_DIR;
      end else if (hit_unmask) begin
        kind_o = write_i ? ACC_UNMASK_WR : ACC_WRONG_DIR;
      end else begin
        kind_o = ACC_UNUSED;
      end
    end
  end

endmodule

// File: rtl/irq_aggr_status.sv
module irq_aggr_status #(
  parameter int N_LINES = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] lines_i,
  output logic [N_LINES-1:0] status_o
);

  // One flop per line; the word follows the input levels
  always_ff @(posedge clk) begin
    if (rst) begin
      status_o <= '0;
    end else begin
      status_o <= lines_i;
    end
  end

  assert_status_follows_R1: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> status_o == $past(lines_i));

endmodule

// File: rtl/irq_aggr_enable.sv
module irq_aggr_enable #(
  parameter int N_LINES = 32,
  parameter int IDX_W   = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr_i,
  input  logic               set_i,
  input  logic [IDX_W-1:0]   idx_i,
  output logic [N_LINES-1:0] en_o
);

  for (genvar g = 0; g < N_LINES; g++) begin : g_bit
    logic sel;
    assign sel = (idx_i == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (rst) begin
        en_o[g] <= 1'b1;
      end else if (clr_i && sel) begin
        en_o[g] <= 1'b0;
      end else if (set_i && sel) begin
        en_o[g] <= 1'b1;
      end
    end
  end

  assert_mask_clears_R3: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> !en_o[$past(idx_i)]);

  assert_unmask_sets_R4: assert property (@(posedge clk) disable iff (rst)
    set_i |=> en_o[$past(idx_i)]);

  assert_quiet_keeps_R7: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && !set_i) |=> $stable(en_o));

endmodule

// File: rtl/irq_aggr_out.sv
module irq_aggr_out #(
  parameter int N_LINES = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] status_i,
  input  logic [N_LINES-1:0] en_i,
  output logic               irq_o
);

  logic [N_LINES-1:0] live;
  assign live = status_i & en_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o <= 1'b0;
    end else begin
      irq_o <= |live;
    end
  end

  assert_irq_rise_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> $past(|status_i));

  assert_irq_fall_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_o) |-> $past(status_i != '1 || en_i != '1));

endmodule

// File: rtl/irq_aggr.sv
module irq_aggr
  import irq_aggr_pkg::*;
#(
  parameter int N_LINES = 32,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] irq_lines_i,
  input  logic               bus_valid_i,
  input  logic               bus_write_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [DATA_W-1:0]  bus_wdata_i,
  output logic [DATA_W-1:0]  bus_rdata_o,
  output logic               err_illegal_o,
  output logic               err_unimpl_o,
  output logic               irq_o
);

  localparam int IDX_W = (N_LINES > 1) ? $clog2(N_LINES) : 1;

  acc_kind_e          kind;
  logic [N_LINES-1:0] status_q;
  logic [N_LINES-1:0] en_q;
  logic [IDX_W-1:0]   line_idx;
  logic               unused_wdata_hi;

  assign line_idx        = bus_wdata_i[IDX_W-1:0];
  assign unused_wdata_hi = ^bus_wdata_i[DATA_W-1:IDX_W];

  irq_aggr_decode #(.ADDR_W(ADDR_W)) u_decode (
    .valid_i (bus_valid_i),
    .write_i (bus_write_i),
    .addr_i  (bus_addr_i),
    .kind_o  (kind)
  );

  irq_aggr_status #(.N_LINES(N_LINES)) u_status (
    .clk      (clk),
    .rst      (rst),
    .lines_i  (irq_lines_i),
    .status_o (status_q)
  );

  irq_aggr_enable #(.N_LINES(N_LINES), .IDX_W(IDX_W)) u_enable (
    .clk   (clk),
    .rst   (rst),
    .clr_i (kind == ACC_MASK_WR),
    .set_i (kind == ACC_UNMASK_WR),
    .idx_i (line_idx),
    .en_o  (en_q)
  );

  irq_aggr_out #(.N_LINES(N_LINES)) u_out (
    .clk      (clk),
    .rst      (rst),
    .status_i (status_q),
    .en_i     (en_q),
    .irq_o    (irq_o)
  );

  // Read data and error pulses, registered at the access edge
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata_o   <= '0;
      err_illegal_o <= 1'b0;
      err_unimpl_o  <= 1'b0;
    end else begin
      err_illegal_o <= (kind == ACC_WRONG_DIR);
      err_unimpl_o  <= (kind == ACC_UNUSED);
      if (bus_valid_i && !bus_write_i) begin
        bus_rdata_o <= (kind == ACC_STATUS_RD) ? DATA_W'(status_q) : '0;
      end
    end
  end

  assert_one_error_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({err_illegal_o, err_unimpl_o}));

  assert_bad_read_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (bus_valid_i && !bus_write_i && bus_addr_i != '0) |=> bus_rdata_o == '0);

  assert_err_follows_access_R7: assert property (@(posedge clk) disable iff (rst)
    !bus_valid_i |=> !err_illegal_o && !err_unimpl_o);

endmodule

// File: tb/irq_aggr_tb.sv
`timescale 1ns/1ps
module irq_aggr_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] lines = '0;
  logic        valid = 1'b0;
  logic        wr = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        e_ill;
  logic        e_uni;
  logic        irq;

  int n_checks = 0;
  int n_fail = 0;
  logic [31:0] exp_en = '1;
  bit done = 0;

  always #5 clk = ~clk;

  irq_aggr dut_i (
    .clk(clk), .rst(rst), .irq_lines_i(lines),
    .bus_valid_i(valid), .bus_write_i(wr), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .err_illegal_o(e_ill), .err_unimpl_o(e_uni), .irq_o(irq)
  );

  function automatic logic exp_irq(logic [31:0] l, logic [31:0] e);
    return |(l & e);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Two edges: status captures, then irq follows
  task automatic settle();
    @(posedge clk); @(posedge clk); #1;
  endtask

  task automatic acc(input logic w, input logic [3:0] a, input logic [31:0] d,
                     output logic [31:0] rd, output logic ill, output logic uni);
    @(negedge clk);
    valid = 1'b1; wr = w; addr = a; wdata = d;
    @(posedge clk); #1;
    rd = rdata; ill = e_ill; uni = e_uni;
    @(negedge clk);
    valid = 1'b0; wr = 1'b0;
    @(posedge clk); #1;
    check("R9 pulse width", {30'd0, e_ill, e_uni}, 32'd0);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    logic [31:0] rd;
    logic ill, uni;
    logic [31:0] prev_rd;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #1;
    // R5 reset state
    check("R5 irq", {31'd0, irq}, 32'd0);
    check("R5 rdata", rdata, 32'd0);
    check("R5 errs", {30'd0, e_ill, e_uni}, 32'd0);
    @(negedge clk); rst = 1'b0;
    lines = 32'h0000_0100;
    settle();
    check("R5 enables all set, R2 irq", {31'd0, irq}, 32'd1);

    // R10/R1 read status
    acc(1'b0, 4'h0, '0, rd, ill, uni);
    check("R10 status read", rd, 32'h0000_0100);
    check("R10 no error", {30'd0, ill, uni}, 32'd0);

    // R3 mask line 8 -> irq falls
    acc(1'b1, 4'h4, 32'd8, rd, ill, uni);
    exp_en[8] = 1'b0;
    check("R3 irq after mask", {31'd0, irq}, 32'd0);
    // R4 unmask with high garbage bits (R6)
    acc(1'b1, 4'h8, 32'hFFFF_FFE8, rd, ill, uni);
    exp_en[8] = 1'b1;
    check("R4 R6 irq after unmask", {31'd0, irq}, 32'd1);
    // R6 mask with high bits, line 31
    @(negedge clk); lines = 32'h8000_0000;
    settle();
    acc(1'b1, 4'h4, 32'h0000_03FF, rd, ill, uni);
    exp_en[31] = 1'b0;
    check("R6 mask idx 31", {31'd0, irq}, 32'd0);

    // R7 write to status
    prev_rd = rdata;
    acc(1'b1, 4'h0, 32'd31, rd, ill, uni);
    check("R7 illegal flag", {30'd0, ill, uni}, 32'd2);
    check("R7 no state change", {31'd0, irq}, 32'd0);
    check("R7 rdata kept", rdata, prev_rd);
    // R8 reads from write-only ports
    acc(1'b0, 4'h4, '0, rd, ill, uni);
    check("R8 mask read flag", {30'd0, ill, uni}, 32'd2);
    check("R8 mask read zero", rd, 32'd0);
    acc(1'b0, 4'h8, '0, rd, ill, uni);
    check("R8 unmask read flag", {30'd0, ill, uni}, 32'd2);
    check("R8 unmask read zero", rd, 32'd0);
    // R9 unused offsets
    acc(1'b0, 4'hC, '0, rd, ill, uni);
    check("R9 unused read flag", {30'd0, ill, uni}, 32'd1);
    check("R9 unused read zero", rd, 32'd0);
    acc(1'b1, 4'h2, 32'd31, rd, ill, uni);
    check("R9 unused write flag", {30'd0, ill, uni}, 32'd1);
    check("R9 unused write no effect", {31'd0, irq}, 32'd0);

    // Random mix
    for (int i = 0; i < 400; i++) begin
      int op;
      logic [31:0] d;
      op = $urandom_range(0, 5);
      d = $urandom;
      case (op)
        0: begin
          @(negedge clk); lines = $urandom & $urandom;
          settle();
          check("R1 R2 irq after line change", {31'd0, irq},
                {31'd0, exp_irq(lines, exp_en)});
        end
        1: begin
          acc(1'b1, 4'h4, d, rd, ill, uni);
          exp_en[d[4:0]] = 1'b0;
          check("R3 R6 mask irq", {31'd0, irq}, {31'd0, exp_irq(lines, exp_en)});
        end
        2: begin
          acc(1'b1, 4'h8, d, rd, ill, uni);
          exp_en[d[4:0]] = 1'b1;
          check("R4 R6 unmask irq", {31'd0, irq}, {31'd0, exp_irq(lines, exp_en)});
        end
        3: begin
          acc(1'b0, 4'h0, '0, rd, ill, uni);
          check("R1 R10 status read", rd, lines);
        end
        4: begin
          acc(d[0], {d[2:1], 2'b11}, d, rd, ill, uni);
          check("R9 odd offset flag", {30'd0, ill, uni}, 32'd1);
          check("R9 state kept", {31'd0, irq}, {31'd0, exp_irq(lines, exp_en)});
        end
        default: begin
          acc(1'b1, 4'h0, d, rd, ill, uni);
          check("R7 status write flag", {30'd0, ill, uni}, 32'd2);
          check("R7 state kept", {31'd0, irq}, {31'd0, exp_irq(lines, exp_en)});
        end
      endcase
    end

    // Mask everything, then drive all lines
    for (int k = 0; k < 32; k++) acc(1'b1, 4'h4, k, rd, ill, uni);
    exp_en = '0;
    @(negedge clk); lines = '1;
    settle();
    check("R3 all masked irq low", {31'd0, irq}, 32'd0);
    acc(1'b1, 4'h8, 32'd0, rd, ill, uni);
    check("R4 line 0 unmasked irq", {31'd0, irq}, 32'd1);

    done = 1;
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

endmodule